// File: doc/BRIEF.md
# SPI Register Access Target

This block lets a host processor read and write a chip's bank of 8-bit control and status registers over a serial link. The host lowers the active-low chip select, clocks in a 16-bit instruction (one read/not-write flag and a 15-bit register address), and then moves data bytes. Writes leave the block as single-cycle strobes on a parallel register-file port. Reads fetch a byte through the same port and shift it back to the host.

Four static configuration inputs choose the bit order, single-byte or multibyte access, the address direction during multibyte access, and the pin arrangement. In 3-wire operation the bidirectional data line returns read data. In 4-wire operation a separate output line returns it. All serial inputs are brought into the system clock domain by synchronizers and handled there, so the serial clock must be well below the system clock (half period of at least six system clocks).

Top module: `spir_target`

## Requirements
- R1: During and after a synchronous active-high reset, both output enables and the write strobe are low.
- R2: With `cfg_msb_first`=1 the instruction arrives as the read flag (1 = read, 0 = write) followed by address bits 14 down to 0, and data bytes travel bit 7 first in both directions.
- R3: With `cfg_msb_first`=0 the whole 16-bit instruction word is reversed: address bit 0 first, address bit 14 fifteenth, read flag last. Data bytes travel bit 0 first in both directions.
- R4: With `cfg_stream`=0 a frame performs at most one register access. Data clocked after the first byte causes no write and no read output.
- R5: With `cfg_stream`=1 each further byte in the frame targets the next address: one higher when `cfg_addr_up`=1, one lower when it is 0. The address wraps modulo 2^15.
- R6: With `cfg_four_wire`=1, read data leaves on `spi_sdo` with `spi_sdo_oe` high during the read data phase, and `spi_sdio_oe` stays low.
- R7: With `cfg_four_wire`=0, read data leaves on `spi_sdio_o` with `spi_sdio_oe` high during the read data phase, and `spi_sdo_oe` stays low.
- R8: Both output enables are low outside a read data phase and while chip select is high.
- R9: Raising chip select before a byte's eighth rising serial clock edge, including in the same system cycle as that edge, discards the byte with no write. The next frame decodes normally.
- R10: A completed write byte gives a one-cycle `rf_we` pulse with `rf_addr` and `rf_wdata` valid in that cycle. `rf_rdata` is taken one system clock after `rf_addr` shows the address read.
- R11: The configuration inputs are sampled when chip select falls. Changes during a frame have no effect until the next frame.
- R12: Input bits are sampled on rising serial clock edges and output bits change only after falling edges (SPI mode 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_msb_first | input | 1 | 1: most significant bit first, 0: least significant first |
| cfg_stream | input | 1 | 1: multibyte frames, 0: one byte per frame |
| cfg_addr_up | input | 1 | 1: address rises per streamed byte, 0: falls |
| cfg_four_wire | input | 1 | 1: read data on spi_sdo, 0: read data on spi_sdio_o |
| spi_sclk | input | 1 | Serial clock from host |
| spi_csn | input | 1 | Active-low chip select |
| spi_sdio_i | input | 1 | Data line input (instruction and write data) |
| spi_sdio_o | output | 1 | Data line output value in 3-wire mode |
| spi_sdio_oe | output | 1 | Drive enable for the shared data line |
| spi_sdo | output | 1 | Separate serial data output in 4-wire mode |
| spi_sdo_oe | output | 1 | Drive enable for spi_sdo |
| rf_addr | output | ADDR_W (15) | Register address |
| rf_wdata | output | DATA_W (8) | Register write data |
| rf_we | output | 1 | Single-cycle write strobe |
| rf_rdata | input | DATA_W (8) | Register read data, one cycle after rf_addr |

## Verification
Two events can land in the same system clock cycle: chip select rising and the detection of the eighth serial clock rising edge of a data byte. The bench provokes this by raising the serial clock and chip select in the same step after seven data bits, so both pass through equal synchronizer depth. It judges the result by the bench register model's write log, which must show no new write, and by a following frame that must complete normally. Randomized frames mix all four configuration inputs, directions and burst lengths around this corner.

// File: rtl/spir_pkg.sv
package spir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INSTR = 2'd1,
    ST_DATA  = 2'd2,
    ST_DONE  = 2'd3
  } spir_state_e;

  typedef struct packed {
    logic msb_first;
    logic stream;
    logic addr_up;
    logic four_wire;
  } spir_cfg_t;

endpackage

// File: rtl/spir_sync.sv
module spir_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spir_shreg.sv
module spir_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  input  logic         msb_first,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (en) begin
      if (msb_first) q <= {q[W-2:0], din};
      else           q <= {din, q[W-1:1]};
    end
  end

endmodule

// File: rtl/spir_ctrl.sv
module spir_ctrl
  import spir_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  localparam int INSTR_W = ADDR_W + 1,
  localparam int CNT_W   = $clog2(INSTR_W),
  localparam int IDX_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csb_s,
  input  logic              sclk_s,
  input  logic              sdio_s,
  input  spir_cfg_t         cfg_in,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic [DATA_W-1:0] tx_byte,
  output logic              rd_phase,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              fall_evt,
  output logic              active,
  output spir_cfg_t         cfg_q
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  LAST_INS = CNT_W'(INSTR_W - 1);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);

  spir_state_e       state;
  logic              sclk_d, csb_d;
  logic              rise_evt, start_evt;
  logic [CNT_W-1:0]  bit_cnt;
  logic              is_rd;
  logic              instr_done, byte_done, step_pend;
  logic [1:0]        fetch_pend;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, tx_q;
  logic              we_q;
  logic [INSTR_W-1:0] ins_word;
  logic [DATA_W-1:0] rx_byte;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic up);
    return up ? (a + ADDR_ONE) : (a - ADDR_ONE);
  endfunction

  // edge detection on synchronized pins
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      csb_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csb_d  <= csb_s;
    end
  end

  assign active    = ~csb_s;
  assign start_evt = ~csb_s & csb_d;
  assign rise_evt  = active & sclk_s & ~sclk_d;
  assign fall_evt  = active & ~sclk_s & sclk_d;

  spir_shreg #(.W(INSTR_W)) u_ins (
    .clk       (clk),
    .rst       (rst),
    .clr       (start_evt),
    .en        (rise_evt && (state == ST_INSTR) && !start_evt),
    .din       (sdio_s),
    .msb_first (cfg_q.msb_first),
    .q         (ins_word)
  );

  spir_shreg #(.W(DATA_W)) u_dat (
    .clk       (clk),
    .rst       (rst),
    .clr       (start_evt),
    .en        (rise_evt && (state == ST_DATA)),
    .din       (sdio_s),
    .msb_first (cfg_q.msb_first),
    .q         (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      is_rd      <= 1'b0;
      instr_done <= 1'b0;
      byte_done  <= 1'b0;
      step_pend  <= 1'b0;
      fetch_pend <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      tx_q       <= '0;
      we_q       <= 1'b0;
      cfg_q      <= '{msb_first: 1'b1, stream: 1'b1, addr_up: 1'b1, four_wire: 1'b1};
    end else begin
      we_q       <= 1'b0;
      fetch_pend <= {fetch_pend[0], 1'b0};
      if (fetch_pend[1]) tx_q <= rf_rdata;

      // completed instruction: decode address and direction
      if (instr_done) begin
        instr_done <= 1'b0;
        addr_q     <= ins_word[ADDR_W-1:0];
        is_rd      <= ins_word[INSTR_W-1];
        if (ins_word[INSTR_W-1]) fetch_pend[0] <= 1'b1;
      end

      // completed data byte: write it, or prefetch the next read byte
      if (byte_done) begin
        byte_done <= 1'b0;
        if (!is_rd) begin
          we_q      <= 1'b1;
          wdata_q   <= rx_byte;
          step_pend <= 1'b1;
        end else if (cfg_q.stream) begin
          addr_q        <= step_addr(addr_q, cfg_q.addr_up);
          fetch_pend[0] <= 1'b1;
        end
      end

      if (step_pend) begin
        step_pend <= 1'b0;
        addr_q    <= step_addr(addr_q, cfg_q.addr_up);
      end

      if (!active) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
      end else if (start_evt) begin
        cfg_q   <= cfg_in;
        state   <= ST_INSTR;
        bit_cnt <= '0;
      end else begin
        case (state)
          ST_INSTR: if (rise_evt) begin
            if (bit_cnt == LAST_INS) begin
              state      <= ST_DATA;
              bit_cnt    <= '0;
              instr_done <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + CNT_W'(1);
            end
          end
          ST_DATA: if (rise_evt) begin
            if (bit_cnt == LAST_BIT) begin
              bit_cnt   <= '0;
              byte_done <= 1'b1;
              if (!cfg_q.stream) state <= ST_DONE;
            end else begin
              bit_cnt <= bit_cnt + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rf_addr  = addr_q;
  assign rf_wdata = wdata_q;
  assign rf_we    = we_q;
  assign tx_byte  = tx_q;
  assign rd_phase = (state == ST_DATA) && is_rd;
  assign bit_idx  = bit_cnt[IDX_W-1:0];

  // checker state: writes seen in the current frame
  logic [1:0]        we_in_frame;
  logic [ADDR_W-1:0] last_we_addr;
  always_ff @(posedge clk) begin
    if (rst || start_evt) begin
      we_in_frame  <= '0;
      last_we_addr <= '0;
    end else if (we_q) begin
      if (we_in_frame != 2'd3) we_in_frame <= we_in_frame + 2'd1;
      last_we_addr <= addr_q;
    end
  end

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we); // R10
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (rf_we && !cfg_q.stream) |-> (we_in_frame == 2'd0)); // R4
  AST_STREAM_STEP: assert property (@(posedge clk) disable iff (rst)
    (rf_we && (we_in_frame != 2'd0)) |->
      (rf_addr == step_addr(last_we_addr, cfg_q.addr_up))); // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !start_evt |=> $stable(cfg_q)); // R11

endmodule

// File: rtl/spir_tx.sv
module spir_tx #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              rd_phase,
  input  logic              fall_evt,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              msb_first,
  input  logic              four_wire,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              sdio_o,
  output logic              sdio_oe
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

  logic out_bit;
  logic pick;

  assign pick = msb_first ? tx_byte[TOP_IDX - bit_idx] : tx_byte[bit_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_bit <= 1'b0;
      sdo_oe  <= 1'b0;
      sdio_oe <= 1'b0;
    end else if (!active || !rd_phase) begin
      sdo_oe  <= 1'b0;
      sdio_oe <= 1'b0;
    end else if (fall_evt) begin
      out_bit <= pick;
      sdo_oe  <= four_wire;
      sdio_oe <= ~four_wire;
    end
  end

  assign sdo    = out_bit;
  assign sdio_o = out_bit;

  AST_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sdo_oe && sdio_oe)); // R6
  AST_OE_FRAME: assert property (@(posedge clk) disable iff (rst)
    (sdo_oe || sdio_oe) |-> $past(active)); // R8
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !fall_evt |=> $stable(out_bit)); // R12

endmodule

// File: rtl/spir_target.sv
module spir_target
  import spir_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_msb_first,
  input  logic              cfg_stream,
  input  logic              cfg_addr_up,
  input  logic              cfg_four_wire,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_sdio_i,
  output logic              spi_sdio_o,
  output logic              spi_sdio_oe,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we,
  input  logic [DATA_W-1:0] rf_rdata
);

  logic [2:0]       pins_s;
  spir_cfg_t        cfg_in, cfg_q;
  logic [DATA_W-1:0] tx_byte;
  logic             rd_phase, fall_evt, active;
  logic [IDX_W-1:0] bit_idx;

  assign cfg_in = '{msb_first: cfg_msb_first, stream: cfg_stream,
                    addr_up: cfg_addr_up, four_wire: cfg_four_wire};

  spir_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_sclk, spi_csn, spi_sdio_i}),
    .q   (pins_s)
  );

  spir_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .csb_s    (pins_s[1]),
    .sclk_s   (pins_s[2]),
    .sdio_s   (pins_s[0]),
    .cfg_in   (cfg_in),
    .rf_rdata (rf_rdata),
    .rf_addr  (rf_addr),
    .rf_wdata (rf_wdata),
    .rf_we    (rf_we),
    .tx_byte  (tx_byte),
    .rd_phase (rd_phase),
    .bit_idx  (bit_idx),
    .fall_evt (fall_evt),
    .active   (active),
    .cfg_q    (cfg_q)
  );

  spir_tx #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .rd_phase  (rd_phase),
    .fall_evt  (fall_evt),
    .bit_idx   (bit_idx),
    .tx_byte   (tx_byte),
    .msb_first (cfg_q.msb_first),
    .four_wire (cfg_q.four_wire),
    .sdo       (spi_sdo),
    .sdo_oe    (spi_sdo_oe),
    .sdio_o    (spi_sdio_o),
    .sdio_oe   (spi_sdio_oe)
  );

  AST_RST_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!spi_sdo_oe && !spi_sdio_oe && !rf_we)); // R1

endmodule

// File: tb/spir_target_test.sv
`timescale 1ns/1ps
module spir_target_test;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic cfg_msb_first = 1'b1, cfg_stream = 1'b1, cfg_addr_up = 1'b1, cfg_four_wire = 1'b1;
  logic spi_sclk = 1'b0, spi_csn = 1'b1, spi_sdio_i = 1'b0;
  logic spi_sdio_o, spi_sdio_oe, spi_sdo, spi_sdo_oe;
  logic [14:0] rf_addr;
  logic [7:0]  rf_wdata;
  logic        rf_we;
  logic [7:0]  rf_rdata;

  spir_target uut (
    .clk(clk), .rst(rst),
    .cfg_msb_first(cfg_msb_first), .cfg_stream(cfg_stream),
    .cfg_addr_up(cfg_addr_up), .cfg_four_wire(cfg_four_wire),
    .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_sdio_i(spi_sdio_i),
    .spi_sdio_o(spi_sdio_o), .spi_sdio_oe(spi_sdio_oe),
    .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_rdata(rf_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 37 + 5);
  endfunction

  // bench-side register file: one-cycle read latency
  logic [7:0]  mem [0:255];
  logic [14:0] wlog_a [0:63];
  logic [7:0]  wlog_d [0:63];
  int          wlog_n = 0;
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else begin
      rf_rdata <= mem[rf_addr[7:0]];
      if (rf_we) begin
        mem[rf_addr[7:0]] <= rf_wdata;
        wlog_a[wlog_n % 64] <= rf_addr;
        wlog_d[wlog_n % 64] <= rf_wdata;
        wlog_n <= wlog_n + 1;
      end
    end
  end

  logic [7:0] shadow [0:255];
  logic [7:0] wbuf [0:7];
  logic [7:0] rbuf [0:7];
  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  function automatic logic [14:0] exp_addr(input logic [14:0] a, input int j, input bit up);
    return up ? 15'(a + 15'(j)) : 15'(a - 15'(j));
  endfunction

  // one serial bit: drive, raise, sample, lower
  task automatic bit_cycle(input logic din, input bit four, output logic dout,
                           output logic oe_used, output logic oe_other);
    spi_sdio_i = din;
    wait_half();
    spi_sclk = 1'b1;
    dout     = four ? spi_sdo : spi_sdio_o;
    oe_used  = four ? spi_sdo_oe : spi_sdio_oe;
    oe_other = four ? spi_sdio_oe : spi_sdo_oe;
    wait_half();
    spi_sclk = 1'b0;
  endtask

  // full frame; f_flip inverts all configuration inputs after instruction bit 4
  task automatic frame(input bit rd, input logic [14:0] a, input int nb,
                       input bit f_msb, input bit f_str, input bit f_up, input bit f_four,
                       input bit f_flip);
    logic [15:0] ins;
    logic d, oe_u, oe_o, b;
    logic [7:0] rb;
    bit exp_oe;
    cfg_msb_first = f_msb; cfg_stream = f_str; cfg_addr_up = f_up; cfg_four_wire = f_four;
    spi_csn = 1'b0;
    wait_half();
    ins = {rd, a};
    for (int i = 0; i < 16; i++) begin
      if (f_flip && i == 4) begin
        cfg_msb_first = ~f_msb; cfg_stream = ~f_str; cfg_addr_up = ~f_up; cfg_four_wire = ~f_four;
      end
      b = f_msb ? ins[15 - i] : ins[i];
      bit_cycle(b, f_four, d, oe_u, oe_o);
      chk(!oe_u && !oe_o, "R8 oe during instruction", {oe_u, oe_o}, 0);
    end
    for (int j = 0; j < nb; j++) begin
      rb = '0;
      exp_oe = rd && (f_str || j == 0);
      for (int k = 0; k < 8; k++) begin
        b = rd ? 1'b0 : wbuf[j][f_msb ? 7 - k : k];
        bit_cycle(b, f_four, d, oe_u, oe_o);
        rb[f_msb ? 7 - k : k] = d;
        chk(oe_u == exp_oe, f_four ? "R6 sdo_oe in data" : "R7 sdio_oe in data", oe_u, exp_oe);
        chk(!oe_o, f_four ? "R6 unused sdio_oe" : "R7 unused sdo_oe", oe_o, 0);
      end
      rbuf[j] = rb;
    end
    wait_half();
    spi_csn = 1'b1;
    repeat (3) wait_half();
    chk(!spi_sdo_oe && !spi_sdio_oe, "R8 oe after frame", {spi_sdo_oe, spi_sdio_oe}, 0);
  endtask

  // frame plus result checks against the shadow model
  task automatic run_frame(input bit rd, input logic [14:0] a, input int nb,
                           input bit f_msb, input bit f_str, input bit f_up, input bit f_four,
                           input bit f_flip, input string tag);
    int base = wlog_n;
    int cnt  = f_str ? nb : 1;
    logic [14:0] ea;
    if (!rd) for (int j = 0; j < nb; j++) wbuf[j] = 8'($urandom);
    frame(rd, a, nb, f_msb, f_str, f_up, f_four, f_flip);
    if (!rd) begin
      chk(wlog_n - base == cnt, {tag, " R4 write count"}, wlog_n - base, cnt);
      for (int j = 0; j < cnt && j < (wlog_n - base); j++) begin
        ea = exp_addr(a, j, f_up);
        chk(wlog_a[(base + j) % 64] == ea, {tag, " R5 write address"}, wlog_a[(base + j) % 64], ea);
        chk(wlog_d[(base + j) % 64] == wbuf[j], {tag, " R10 write data"}, wlog_d[(base + j) % 64], wbuf[j]);
        shadow[ea[7:0]] = wbuf[j];
      end
    end else begin
      chk(wlog_n == base, {tag, " R4 no write on read"}, wlog_n - base, 0);
      for (int j = 0; j < cnt; j++) begin
        ea = exp_addr(a, j, f_up);
        chk(rbuf[j] == shadow[ea[7:0]], {tag, f_msb ? " R2 read byte" : " R3 read byte"},
            rbuf[j], shadow[ea[7:0]]);
      end
    end
  endtask

  // aborted frame: nbits clocked, the last one optionally coinciding with CSB release
  task automatic partial(input logic [14:0] a, input int nbits, input bit collide, input string tag);
    int base = wlog_n;
    logic [15:0] ins = {1'b0, a};
    cfg_msb_first = 1'b1; cfg_stream = 1'b1; cfg_addr_up = 1'b1; cfg_four_wire = 1'b1;
    spi_csn = 1'b0;
    wait_half();
    for (int i = 0; i < nbits; i++) begin
      spi_sdio_i = (i < 16) ? ins[15 - i] : 1'b1;
      wait_half();
      spi_sclk = 1'b1;
      if (collide && i == nbits - 1) spi_csn = 1'b1;
      wait_half();
      spi_sclk = 1'b0;
    end
    wait_half();
    spi_csn = 1'b1;
    repeat (3) wait_half();
    chk(wlog_n == base, {tag, " R9 no write from aborted byte"}, wlog_n - base, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < 256; i++) shadow[i] = init_val(i);
    repeat (4) @(negedge clk);
    chk(!spi_sdo_oe && !spi_sdio_oe && !rf_we, "R1 during reset", {spi_sdo_oe, spi_sdio_oe, rf_we}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(!spi_sdo_oe && !spi_sdio_oe && !rf_we, "R1 after reset", {spi_sdo_oe, spi_sdio_oe, rf_we}, 0);

    // directed corners
    run_frame(1'b0, 15'h0010, 3, 1, 1, 1, 1, 0, "R2 msb write up");
    run_frame(1'b1, 15'h0010, 3, 1, 1, 1, 0, 0, "R7 msb read 3wire");
    run_frame(1'b0, 15'h0001, 3, 0, 1, 0, 1, 0, "R3 lsb write down wrap");
    run_frame(1'b1, 15'h0001, 3, 0, 1, 0, 1, 0, "R6 lsb read down wrap");
    run_frame(1'b0, 15'h7FFF, 2, 1, 1, 1, 0, 0, "R5 up wrap");
    run_frame(1'b0, 15'h0040, 3, 1, 0, 1, 1, 0, "R4 single write");
    run_frame(1'b1, 15'h0041, 2, 0, 0, 1, 1, 0, "R4 single read");
    run_frame(1'b0, 15'h0050, 1, 1, 0, 1, 1, 1, "R11 cfg flip");
    run_frame(1'b1, 15'h0050, 2, 0, 1, 0, 0, 1, "R11 cfg flip read");
    partial(15'h0060, 10, 1'b0, "R9 mid instruction");
    partial(15'h0060, 20, 1'b0, "R9 mid data");
    partial(15'h0060, 24, 1'b1, "R9 release with eighth edge");
    run_frame(1'b1, 15'h0060, 1, 1, 1, 1, 1, 0, "R9 after abort");
    run_frame(1'b0, 15'h0060, 1, 1, 1, 1, 1, 0, "R12 write after abort");

    // random frames
    for (int n = 0; n < 36; n++) begin
      run_frame(1'($urandom), 15'($urandom), 1 + int'($urandom % 3),
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0, "rand R12");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

endmodule